// File: doc/BRIEF.md
# 24-Hour Digital Clock Core with Rounding Seconds Clear

This block keeps the time of day from a fast reference clock. A divider turns the reference into a one-cycle tick once per second. Three counters in a chain hold seconds (0 to 59), minutes (0 to 59) and hours (0 to 23). Every counter moves on tick enables in the single reference clock domain, and no clock is derived from another.

Four active-low push buttons act on the core. Each raw button line is synchronized and edge-detected, so one press gives one event however long it is held.
- The clear button zeroes the seconds and rounds to the nearest minute: at 30 seconds or more it also adds one minute.
- The minute-set and hour-set buttons each add one to their counter, with normal wrap and carry.
- The view button swaps the four static seven-segment digits between hours:minutes and minutes:seconds.

Debouncing and multiplexed digit scanning belong to the surrounding logic.

Top module: `clock24_core`

## Requirements
- R1: While `rst` is high at a clock edge, the divider and all three counters clear to 00:00:00 and the view returns to hours:minutes, so all four digits show the pattern for 0.
- R2: The seconds counter advances by one every TICK_DIV reference cycles, counted from the release of reset. The default TICK_DIV is 27,000,000, which gives 1 Hz from 27 MHz.
- R3: The seconds counter wraps from 59 to 0 and passes a carry to the minutes counter in the same cycle.
- R4: A clear event sets the seconds to 0 on the next edge and wins over a tick in the same cycle. If the seconds were 30 or more, the event also carries one into the minutes. If they were 29 or less, the minutes are not touched.
- R5: A minute-set event adds one to the minutes, which run 0 to 59 and wrap with a carry into the hours. A minute-set event in the same cycle as a seconds carry adds two.
- R6: An hour-set event adds one to the hours, which run 0 to 23 and wrap to 0. An hour-set event in the same cycle as a minutes carry adds two.
- R7: Buttons are active-low: a line reads 0 while pressed. An event occurs once, on the synchronized 1-to-0 transition, and takes effect on the third rising edge after the line falls. Holding a button or releasing it produces no further event.
- R8: Each view-button event toggles the view. In hours:minutes view the high pair shows hours and the low pair shows minutes. In minutes:seconds view the high pair shows minutes and the low pair shows seconds.
- R9: Each shown value is split into a tens digit and a units digit. Each digit drives seven active-high segments with bit 0 = a through bit 6 = g, using these digit patterns:
  - 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66
  - 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_clear_n | input | 1 | Seconds clear with rounding, active low |
| btn_min_n | input | 1 | Minute set, active low |
| btn_hour_n | input | 1 | Hour set, active low |
| btn_view_n | input | 1 | View toggle, active low |
| seg_hi_tens | output | 7 | Segments, tens digit of high pair |
| seg_hi_units | output | 7 | Segments, units digit of high pair |
| seg_lo_tens | output | 7 | Segments, tens digit of low pair |
| seg_lo_units | output | 7 | Segments, units digit of low pair |

## Verification
The bench runs the core with a four-cycle divider. It checks every cycle against an arithmetic model that keeps the time as seconds of the day.

Clear presses land on both sides of the 30-second threshold. A design with the threshold off by one would gain or lose a minute at 29 or 30 seconds.

Clear, minute and hour presses are also swept across every divider phase next to a carry. A design that drops one of two coincident increments, or lets a tick beat a clear, falls one step behind the model. Long holds catch a design that re-fires while a button stays pressed. Rollovers at 59 and 23 catch a missing or extra carry.

// File: rtl/clock24_pkg.sv
package clock24_pkg;

  // Segment pattern for one decimal digit, bit 0 = segment a
  function automatic logic [6:0] digit_segments(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  function automatic logic [3:0] tens_digit(input logic [6:0] v);
    return 4'(v / 7'd10);
  endfunction

  function automatic logic [3:0] units_digit(input logic [6:0] v);
    return 4'(v % 7'd10);
  endfunction

endpackage

// File: rtl/clock24_btn.sv
module clock24_btn #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  output logic press
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], btn_n};
      level_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign press = level_q & ~sync_q[SYNC_STAGES-1];

  // R7: one press gives a single-cycle event
  p_single_event_r7: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

endmodule

// File: rtl/clock24_divider.sv
module clock24_divider #(
  parameter int unsigned DIV = 27_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)            count_q <= '0;
    else if (tick)      count_q <= '0;
    else                count_q <= count_q + 1'b1;
  end

  assign tick = (count_q == LAST);

  // R2: counter never passes the terminal count
  p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R2: two ticks are never adjacent
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/clock24_modctr.sv
module clock24_modctr #(
  parameter int unsigned MODULUS = 60
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       inc_a,
  input  logic                       inc_b,
  output logic [$clog2(MODULUS)-1:0] value,
  output logic                       wrap
);
  localparam int W = $clog2(MODULUS);
  localparam logic [W:0] MODV = (W+1)'(MODULUS);

  logic [W:0]   sum;
  logic [W-1:0] next_val;

  always_comb begin
    sum  = {1'b0, value} + (W+1)'(inc_a) + (W+1)'(inc_b);
    wrap = !clr && (sum >= MODV);
    if (clr)       next_val = '0;
    else if (wrap) next_val = W'(sum - MODV);
    else           next_val = W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= next_val;
  end

  // R3 R5 R6: value stays inside its modulus
  p_value_range_r5: assert property (@(posedge clk) disable iff (rst)
    value < W'(MODULUS));

  // R4: a clear lands on zero
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> value == '0);

endmodule

// File: rtl/clock24_core.sv
module clock24_core #(
  parameter int unsigned TICK_DIV    = 27_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_clear_n,
  input  logic       btn_min_n,
  input  logic       btn_hour_n,
  input  logic       btn_view_n,
  output logic [6:0] seg_hi_tens,
  output logic [6:0] seg_hi_units,
  output logic [6:0] seg_lo_tens,
  output logic [6:0] seg_lo_units
);
  import clock24_pkg::*;

  localparam int unsigned SEC_MOD  = 60;
  localparam int unsigned MIN_MOD  = 60;
  localparam int unsigned HR_MOD   = 24;
  localparam int SEC_W = $clog2(SEC_MOD);
  localparam int MIN_W = $clog2(MIN_MOD);
  localparam int HR_W  = $clog2(HR_MOD);
  localparam logic [SEC_W-1:0] ROUND_AT = SEC_W'(SEC_MOD / 2);

  // named internal events
  logic sec_tick, clear_ev, min_ev, hour_ev, view_ev;
  logic sec_wrap, round_carry, sec_carry, min_wrap, hr_wrap;
  logic [SEC_W-1:0] sec_val;
  logic [MIN_W-1:0] min_val;
  logic [HR_W-1:0]  hr_val;
  logic             view_ms_q;

  clock24_divider #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(sec_tick));

  clock24_btn #(.SYNC_STAGES(SYNC_STAGES)) u_btn_clear (
    .clk(clk), .rst(rst), .btn_n(btn_clear_n), .press(clear_ev));
  clock24_btn #(.SYNC_STAGES(SYNC_STAGES)) u_btn_min (
    .clk(clk), .rst(rst), .btn_n(btn_min_n), .press(min_ev));
  clock24_btn #(.SYNC_STAGES(SYNC_STAGES)) u_btn_hour (
    .clk(clk), .rst(rst), .btn_n(btn_hour_n), .press(hour_ev));
  clock24_btn #(.SYNC_STAGES(SYNC_STAGES)) u_btn_view (
    .clk(clk), .rst(rst), .btn_n(btn_view_n), .press(view_ev));

  clock24_modctr #(.MODULUS(SEC_MOD)) u_sec (
    .clk(clk), .rst(rst), .clr(clear_ev), .inc_a(sec_tick), .inc_b(1'b0),
    .value(sec_val), .wrap(sec_wrap));

  assign round_carry = clear_ev && (sec_val >= ROUND_AT);
  assign sec_carry   = sec_wrap | round_carry;

  clock24_modctr #(.MODULUS(MIN_MOD)) u_min (
    .clk(clk), .rst(rst), .clr(1'b0), .inc_a(sec_carry), .inc_b(min_ev),
    .value(min_val), .wrap(min_wrap));

  clock24_modctr #(.MODULUS(HR_MOD)) u_hr (
    .clk(clk), .rst(rst), .clr(1'b0), .inc_a(min_wrap), .inc_b(hour_ev),
    .value(hr_val), .wrap(hr_wrap));

  always_ff @(posedge clk) begin
    if (rst)          view_ms_q <= 1'b0;
    else if (view_ev) view_ms_q <= ~view_ms_q;
  end

  logic [6:0] hi_val, lo_val;
  always_comb begin
    if (view_ms_q) begin
      hi_val = 7'(min_val);
      lo_val = 7'(sec_val);
    end else begin
      hi_val = 7'(hr_val);
      lo_val = 7'(min_val);
    end
  end

  assign seg_hi_tens  = digit_segments(tens_digit(hi_val));
  assign seg_hi_units = digit_segments(units_digit(hi_val));
  assign seg_lo_tens  = digit_segments(tens_digit(lo_val));
  assign seg_lo_units = digit_segments(units_digit(lo_val));

  // R4: rounding up carries exactly one minute
  p_round_up_r4: assert property (@(posedge clk) disable iff (rst)
    (clear_ev && sec_val >= ROUND_AT && !min_ev) |=>
      (min_val == (($past(min_val) == MIN_W'(MIN_MOD-1)) ? '0 : $past(min_val) + 1'b1)));

  // R4: clearing below the threshold leaves minutes alone
  p_round_down_r4: assert property (@(posedge clk) disable iff (rst)
    (clear_ev && sec_val < ROUND_AT && !min_ev) |=> $stable(min_val));

  // R3: tick at 59 without clear gives 0
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !clear_ev && sec_val == SEC_W'(SEC_MOD-1)) |=> sec_val == '0);

  // R6: hour set at 23 alone wraps to 0
  p_hour_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (hour_ev && !min_wrap && hr_val == HR_W'(HR_MOD-1)) |=> hr_val == '0);

  // R8: a view event flips the view
  p_view_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    view_ev |=> view_ms_q != $past(view_ms_q));

  // R9: every digit is a valid pattern
  p_seg_valid_r9: assert property (@(posedge clk) disable iff (rst)
    seg_hi_tens != 7'h00 && seg_lo_units != 7'h00);

endmodule

// File: tb/clock24_core_bench.sv
module clock24_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int DAY = 86400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] btn_n = 4'hF;   // 0 clear, 1 min, 2 hour, 3 view
  logic [6:0] s_ht, s_hu, s_lt, s_lu;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  clock24_core #(.TICK_DIV(DIV)) u_clock24_core (
    .clk(clk), .rst(rst),
    .btn_clear_n(btn_n[0]), .btn_min_n(btn_n[1]),
    .btn_hour_n(btn_n[2]), .btn_view_n(btn_n[3]),
    .seg_hi_tens(s_ht), .seg_hi_units(s_hu),
    .seg_lo_tens(s_lt), .seg_lo_units(s_lu));

  // segment table written per lit segments (bit0=a .. bit6=g)
  logic [6:0] segtab [10];
  initial begin
    segtab[0] = 7'b0111111; segtab[1] = 7'b0000110;
    segtab[2] = 7'b1011011; segtab[3] = 7'b1001111;
    segtab[4] = 7'b1100110; segtab[5] = 7'b1101101;
    segtab[6] = 7'b1111101; segtab[7] = 7'b0000111;
    segtab[8] = 7'b1111111; segtab[9] = 7'b1101111;
  end

  // arithmetic model: time as seconds of the day
  int  mtime, mdiv;
  bit  mview;
  logic [3:0] d1, d2, d3;

  always @(posedge clk) begin : model
    int s, delta;
    logic [3:0] ev;
    bit tk;
    if (rst) begin
      d1 <= 4'hF; d2 <= 4'hF; d3 <= 4'hF;
      mtime <= 0; mdiv <= 0; mview <= 1'b0;
    end else begin
      ev = d3 & ~d2;
      tk = (mdiv == DIV - 1);
      s  = mtime % 60;
      if (ev[0]) delta = (s >= 30) ? (60 - s) : -s;
      else       delta = tk ? 1 : 0;
      if (ev[1]) delta += 60;
      if (ev[2]) delta += 3600;
      mtime <= (mtime + delta + DAY) % DAY;
      mdiv  <= tk ? 0 : mdiv + 1;
      if (ev[3]) mview <= ~mview;
      d1 <= btn_n; d2 <= d1; d3 <= d2;
    end
  end

  function automatic int m_hr();  return mtime / 3600;       endfunction
  function automatic int m_min(); return (mtime / 60) % 60;  endfunction
  function automatic int m_sec(); return mtime % 60;         endfunction

  task automatic compare(input string req);
    int hi, lo;
    logic [27:0] exp_v, act_v;
    hi = mview ? m_min() : m_hr();
    lo = mview ? m_sec() : m_min();
    exp_v = {segtab[hi/10], segtab[hi%10], segtab[lo/10], segtab[lo%10]};
    act_v = {s_ht, s_hu, s_lt, s_lu};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h (time %0d:%0d:%0d view=%0d)",
               req, $time, act_v, exp_v, m_hr(), m_min(), m_sec(), mview);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) compare(cur_req);

  task automatic press(input int idx, input int hold);
    @(negedge clk) btn_n[idx] = 1'b0;
    repeat (hold) @(negedge clk);
    btn_n[idx] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_sec(input int s);
    while (m_sec() != s) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, explicit zeros in hours:minutes view
    cur_req = "R1";
    checks++;
    if ({s_ht, s_hu, s_lt, s_lu} !== {4{7'h3F}}) begin
      failures++;
      $display("FAIL R1 reset digits actual=%h expected=%h",
               {s_ht, s_hu, s_lt, s_lu}, {4{7'h3F}});
    end
    rst = 1'b0;
    chk_on = 1'b1;
    repeat (5) @(negedge clk);

    // R8: switch to minutes:seconds, run past a seconds wrap (R2 R3 R9)
    cur_req = "R8"; press(3, 2);
    cur_req = "R2"; repeat (DIV * 10) @(negedge clk);
    cur_req = "R3"; repeat (DIV * 65) @(negedge clk);

    // R4: clear on both sides of the threshold, including 29 and 30
    cur_req = "R4";
    foreach (segtab[i]) begin end
    for (int k = 0; k < 4; k++) begin
      int tgt;
      tgt = (k == 0) ? 10 : (k == 1) ? 45 : (k == 2) ? 27 : 28; // lands 29/30 area
      wait_sec(tgt);
      press(0, 1 + k);
    end
    // clear against a tick in every divider phase, at 29 and at 30
    for (int ph = 0; ph < DIV; ph++) begin
      for (int j = 0; j < 2; j++) begin
        wait_sec(29 + j);
        while (mdiv != ph) @(negedge clk);
        press(0, 1);
      end
    end

    // R7: long holds give one event each
    cur_req = "R7";
    press(1, 50);
    press(2, 40);
    press(0, 30);

    // R5: minute presses through a minutes wrap
    cur_req = "R5";
    for (int k = 0; k < 62; k++) press(1, 1 + (k % 3));
    // minute press coinciding with a seconds carry, every phase
    for (int ph = 0; ph < DIV + 3; ph++) begin
      wait_sec(59);
      while (mdiv != (ph % DIV)) @(negedge clk);
      press(1, 1);
    end

    // R6: hour presses through 23 -> 0 in hours:minutes view
    cur_req = "R8"; press(3, 3);
    cur_req = "R6";
    for (int k = 0; k < 26; k++) press(2, 1);
    // hour press coinciding with a minutes carry
    for (int ph = 0; ph < DIV + 3; ph++) begin
      int need;
      need = (59 - m_min() + 60) % 60;
      for (int k = 0; k < need; k++) press(1, 1);
      wait_sec(59);
      if (m_min() != 59) continue;
      while (mdiv != (ph % DIV)) @(negedge clk);
      press(2, 1);
    end

    // R9: several view flips over changing values
    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin
      press(3, 1);
      repeat (DIV * 3) @(negedge clk);
    end

    // R1: reset in mid-run returns to zero and hours:minutes view
    cur_req = "R1";
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_on = 1'b0;
    finish_run();
  end

endmodule